// File: doc/BRIEF.md
# Two-Way Doorbell Register Pair

The block holds two doorbell registers. A host-side port and a local-side port share them, and both ports run on one clock. In the outbound register, the local port raises flags and the host port acknowledges them. In the inbound register, the host port raises flags and the local port acknowledges them. Each register drives a level interrupt toward the side that reads it, and a plain enable input gates that interrupt.

Only one port may use the register bank at a time.

- **Local port (valid/ready stream):** the local side raises `lcl_valid` and holds its command stable until `lcl_ready` is high. Each cycle with both signals high is one completed access. While `lcl_valid` stays high, the local port keeps the bank, so a run of back-to-back accesses is one uninterrupted burst.
- **Host port (transaction with retry):** the host side raises `hst_req` for the length of its transaction. The write takes effect in the first cycle the transaction is granted. If the local port holds the bank, `hst_retry` rises, nothing changes, and the host must come back later.
- **Arbitration:** the port that started first keeps the bank. When both ports start from idle in the same cycle, the host wins.

Top module: `doorbell_pair`

## Requirements
- R1: After reset, both registers read zero and both interrupts are low.
- R2: A granted local write to the outbound register (sel = 0) sets every bit where the write data is 1. Bits where the data is 0 keep their value.
- R3: A granted host write to the outbound register (sel = 0) clears every bit where the write data is 1. It never sets a bit.
- R4: A granted host write to the inbound register (sel = 1) sets every bit where the write data is 1. Bits where the data is 0 keep their value.
- R5: A granted local write to the inbound register (sel = 1) clears every bit where the write data is 1. It never sets a bit.
- R6: `irq_host` is high exactly when `irq_host_en` is high and any outbound bit is set.
- R7: `irq_local` is high exactly when `irq_local_en` is high and any inbound bit is set.
- R8: Each port's read data shows the current value of the register its sel picks. Reads change nothing.
- R9: While the host holds the bank (its `hst_req` is still high after it was granted), `lcl_ready` stays low. `lcl_ready` rises in the first cycle that `hst_req` is low.
- R10: While the local port holds the bank (its `lcl_valid` is still high after it was granted), a host request sees `hst_retry` high.
- R11: When both ports start a request in the same cycle from idle, the host is granted (`hst_retry` low) and `lcl_ready` is low.
- R12: A host transaction that sees `hst_retry` changes no register. A host write only takes effect in the first granted cycle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host transaction active, held for its length |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_sel | input | 1 | Host target: 0 outbound, 1 inbound |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Register selected by hst_sel |
| hst_retry | output | 1 | Host must retry; the access had no effect |
| lcl_valid | input | 1 | Local command valid |
| lcl_ready | output | 1 | Local command accepted this cycle |
| lcl_we | input | 1 | Local write (1) or read (0) |
| lcl_sel | input | 1 | Local target: 0 outbound, 1 inbound |
| lcl_wdata | input | DATA_W | Local write data |
| lcl_rdata | output | DATA_W | Register selected by lcl_sel |
| irq_host_en | input | 1 | Host interrupt enable |
| irq_local_en | input | 1 | Local interrupt enable |
| irq_host | output | 1 | Level interrupt toward the host |
| irq_local | output | 1 | Level interrupt toward the local side |

## Verification
The assertions check, on every cycle:
- that a bit can only rise on a cycle with a set access, and only fall on a cycle with a clear access;
- that an owning port keeps the bank while its request is held;
- that the host wins a tie from idle;
- that an interrupt follows a set when its enable is high.

The bench's scenarios are needed to show what a cycle-by-cycle property cannot:
- the exact bit values after mixed set and clear sequences;
- that a retried host write leaves no trace;
- when `lcl_ready` returns after a host transaction ends.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_HOST  = 2'd1,
    OWN_LOCAL = 2'd2
  } owner_e;

  localparam logic SEL_OUTBOUND = 1'b0;
  localparam logic SEL_INBOUND  = 1'b1;
endpackage

// File: rtl/doorbell_arbiter.sv
module doorbell_arbiter
  import doorbell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hst_req,
  input  logic lcl_valid,
  output logic hst_grant,
  output logic hst_start,
  output logic lcl_grant
);
  owner_e owner_q, owner_d;

  // The current owner keeps the bank while its request is held.
  // From idle, the host wins a tie.
  always_comb begin
    owner_d = owner_q;
    if (owner_q == OWN_HOST && !hst_req)    owner_d = OWN_NONE;
    if (owner_q == OWN_LOCAL && !lcl_valid) owner_d = OWN_NONE;
    if (owner_d == OWN_NONE) begin
      if (hst_req)        owner_d = OWN_HOST;
      else if (lcl_valid) owner_d = OWN_LOCAL;
    end
  end

  assign hst_grant = (owner_d == OWN_HOST);
  assign lcl_grant = (owner_d == OWN_LOCAL);
  assign hst_start = hst_grant && (owner_q != OWN_HOST);

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  p_host_keeps_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hst_grant) && hst_req) |-> !lcl_grant);

  p_local_keeps_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lcl_grant) && lcl_valid) |-> !hst_grant);

  p_host_wins_tie_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hst_req) && !$past(lcl_valid) && hst_req && lcl_valid) |-> (hst_grant && !lcl_grant));
endmodule

// File: rtl/doorbell_reg.sv
module doorbell_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] set_mask, clr_mask;

  assign set_mask = set_en ? set_bits : '0;
  assign clr_mask = clr_en ? clr_bits : '0;

  // The set is applied after the clear, so a set wins on the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end

  // Covers R3 and R5: the clearing side can never raise a bit.
  p_no_rise_without_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(set_en) |-> ((q & ~$past(q)) == '0));

  // Covers R2 and R4: writing zeros from the setting side keeps the bits.
  p_no_fall_without_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_en) |-> (($past(q) & ~q) == '0));
endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic              hst_sel,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_retry,
  input  logic              lcl_valid,
  output logic              lcl_ready,
  input  logic              lcl_we,
  input  logic              lcl_sel,
  input  logic [DATA_W-1:0] lcl_wdata,
  output logic [DATA_W-1:0] lcl_rdata,
  input  logic              irq_host_en,
  input  logic              irq_local_en,
  output logic              irq_host,
  output logic              irq_local
);
  logic hst_grant, hst_start, lcl_grant;
  logic hst_wr, lcl_wr;
  logic [DATA_W-1:0] out_q, in_q;

  doorbell_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_req   (hst_req),
    .lcl_valid (lcl_valid),
    .hst_grant (hst_grant),
    .hst_start (hst_start),
    .lcl_grant (lcl_grant)
  );

  assign hst_wr    = hst_start && hst_we;
  assign lcl_wr    = lcl_grant && lcl_we;
  assign hst_retry = hst_req && !hst_grant;
  assign lcl_ready = lcl_grant;

  // Outbound: the local side sets, the host side clears.
  doorbell_reg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (lcl_wr && lcl_sel == SEL_OUTBOUND),
    .set_bits (lcl_wdata),
    .clr_en   (hst_wr && hst_sel == SEL_OUTBOUND),
    .clr_bits (hst_wdata),
    .q        (out_q)
  );

  // Inbound: the host side sets, the local side clears.
  doorbell_reg #(.DATA_W(DATA_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (hst_wr && hst_sel == SEL_INBOUND),
    .set_bits (hst_wdata),
    .clr_en   (lcl_wr && lcl_sel == SEL_INBOUND),
    .clr_bits (lcl_wdata),
    .q        (in_q)
  );

  assign hst_rdata = (hst_sel == SEL_INBOUND) ? in_q : out_q;
  assign lcl_rdata = (lcl_sel == SEL_INBOUND) ? in_q : out_q;
  assign irq_host  = irq_host_en && (|out_q);
  assign irq_local = irq_local_en && (|in_q);

  p_host_irq_follows_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_host_en && $past(lcl_wr && lcl_sel == SEL_OUTBOUND && (|lcl_wdata))) |-> irq_host);

  p_local_irq_follows_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_local_en && $past(hst_wr && hst_sel == SEL_INBOUND && (|hst_wdata))) |-> irq_local);

  p_single_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcl_ready && hst_req && !hst_retry));
endmodule

// File: tb/doorbell_pair_bench.sv
module doorbell_pair_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_req = 1'b0, hst_we = 1'b0, hst_sel = 1'b0;
  logic [W-1:0] hst_wdata = '0;
  logic [W-1:0] hst_rdata;
  logic hst_retry;
  logic lcl_valid = 1'b0, lcl_we = 1'b0, lcl_sel = 1'b0;
  logic lcl_ready;
  logic [W-1:0] lcl_wdata = '0;
  logic [W-1:0] lcl_rdata;
  logic en_h = 1'b1, en_l = 1'b1;
  logic irq_host, irq_local;

  int total = 0;
  int fails = 0;
  logic [W-1:0] ob_m = '0, ib_m = '0;

  always #4 clk = ~clk;

  doorbell_pair #(.DATA_W(W)) u_doorbell_pair (
    .clk(clk), .rst_n(rst_n),
    .hst_req(hst_req), .hst_we(hst_we), .hst_sel(hst_sel), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_retry(hst_retry),
    .lcl_valid(lcl_valid), .lcl_ready(lcl_ready), .lcl_we(lcl_we), .lcl_sel(lcl_sel),
    .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
    .irq_host_en(en_h), .irq_local_en(en_l), .irq_host(irq_host), .irq_local(irq_local)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] host_effect(input logic sel, input logic [W-1:0] d,
                                               input logic [W-1:0] cur);
    return sel ? (cur | d) : (cur & ~d);
  endfunction

  function automatic logic [W-1:0] local_effect(input logic sel, input logic [W-1:0] d,
                                                input logic [W-1:0] cur);
    return sel ? (cur & ~d) : (cur | d);
  endfunction

  task automatic check_irqs(input string tag);
    chk({tag, " R6 irq_host"}, W'(irq_host), W'(en_h && (|ob_m)));
    chk({tag, " R7 irq_local"}, W'(irq_local), W'(en_l && (|ib_m)));
  endtask

  // One idle-to-idle host transaction lasting a single cycle.
  task automatic host_op(input logic sel, input logic we, input logic [W-1:0] d);
    @(negedge clk);
    hst_req = 1'b1; hst_sel = sel; hst_we = we; hst_wdata = d;
    #1;
    chk("R12 host granted from idle", W'(hst_retry), '0);
    chk("R8 host read", hst_rdata, sel ? ib_m : ob_m);
    @(posedge clk);
    if (we) begin
      if (sel) ib_m = host_effect(1'b1, d, ib_m);
      else     ob_m = host_effect(1'b0, d, ob_m);
    end
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0;
    #1;
    check_irqs("host_op");
  endtask

  // One idle-to-idle local handshake.
  task automatic local_op(input logic sel, input logic we, input logic [W-1:0] d);
    @(negedge clk);
    lcl_valid = 1'b1; lcl_sel = sel; lcl_we = we; lcl_wdata = d;
    #1;
    chk("R8 local ready from idle", W'(lcl_ready), W'(1));
    chk("R8 local read", lcl_rdata, sel ? ib_m : ob_m);
    @(posedge clk);
    if (we) begin
      if (sel) ib_m = local_effect(1'b1, d, ib_m);
      else     ob_m = local_effect(1'b0, d, ob_m);
    end
    @(negedge clk);
    lcl_valid = 1'b0; lcl_we = 1'b0;
    #1;
    check_irqs("local_op");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d0b_e115));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    hst_sel = 1'b0; lcl_sel = 1'b1;
    chk("R1 outbound zero", hst_rdata, '0);
    chk("R1 inbound zero", lcl_rdata, '0);
    chk("R1 irq_host low", W'(irq_host), '0);
    chk("R1 irq_local low", W'(irq_local), '0);

    // R2: local sets outbound, zeros keep bits
    local_op(1'b0, 1'b1, 32'h0000_00F0);
    local_op(1'b0, 1'b1, 32'h0000_000F);
    local_op(1'b0, 1'b1, 32'h0000_0000);
    host_op(1'b0, 1'b0, '0);
    chk("R2 outbound after sets", ob_m, 32'h0000_00FF);

    // R3: host clears outbound and never sets
    host_op(1'b0, 1'b1, 32'hFFFF_0F0F);
    local_op(1'b0, 1'b0, '0);
    chk("R3 outbound after clear", ob_m, 32'h0000_00F0);

    // R4 / R5: inbound direction
    host_op(1'b1, 1'b1, 32'h8000_0001);
    local_op(1'b1, 1'b1, 32'h0000_0001);
    host_op(1'b1, 1'b0, '0);
    chk("R5 inbound after local clear", ib_m, 32'h8000_0000);

    // R6 / R7: interrupt enables
    en_h = 1'b0; en_l = 1'b0;
    #1; check_irqs("enables off");
    en_h = 1'b1; en_l = 1'b1;
    #1; check_irqs("enables on");

    // R9: the host holds the bank, so the local port waits
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_sel = 1'b1; hst_wdata = 32'h0000_0300;
    #1; chk("R9 host granted", W'(hst_retry), '0);
    @(posedge clk); ib_m = ib_m | 32'h0000_0300;
    @(negedge clk);
    lcl_valid = 1'b1; lcl_we = 1'b1; lcl_sel = 1'b1; lcl_wdata = 32'h0000_0100;
    #1;
    chk("R9 local stalled", W'(lcl_ready), '0);
    chk("R12 held host write applied once", hst_rdata, ib_m);
    @(negedge clk);
    #1; chk("R9 local still stalled", W'(lcl_ready), '0);
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0;
    #1; chk("R9 local ready on host release", W'(lcl_ready), W'(1));
    @(posedge clk); ib_m = ib_m & ~32'h0000_0100;
    @(negedge clk);
    lcl_valid = 1'b0; lcl_we = 1'b0;
    host_op(1'b1, 1'b0, '0);

    // R10 / R12: the local port holds the bank, so the host is retried
    @(negedge clk);
    lcl_valid = 1'b1; lcl_we = 1'b0; lcl_sel = 1'b1;
    #1; chk("R10 local granted", W'(lcl_ready), W'(1));
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_sel = 1'b1; hst_wdata = 32'h0F00_0000;
    #1; chk("R10 host retried", W'(hst_retry), W'(1));
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0;
    @(negedge clk);
    lcl_valid = 1'b0;
    host_op(1'b1, 1'b0, '0);
    chk("R12 retried write left inbound", ib_m, 32'h8000_0200);

    // R11: simultaneous start from idle, the host wins
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_sel = 1'b0; hst_wdata = 32'h0000_00F0;
    lcl_valid = 1'b1; lcl_we = 1'b1; lcl_sel = 1'b0; lcl_wdata = 32'h0000_0005;
    #1;
    chk("R11 host granted on tie", W'(hst_retry), '0);
    chk("R11 local waits on tie", W'(lcl_ready), '0);
    @(posedge clk); ob_m = ob_m & ~32'h0000_00F0;
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0;
    #1; chk("R11 local follows", W'(lcl_ready), W'(1));
    @(posedge clk); ob_m = ob_m | 32'h0000_0005;
    @(negedge clk);
    lcl_valid = 1'b0; lcl_we = 1'b0;
    local_op(1'b0, 1'b0, '0);
    chk("R11 outbound after tie", ob_m, 32'h0000_0005);

    // Random mix of single accesses from both sides
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] d;
      logic side, sel, we;
      d    = $urandom() & $urandom();
      side = 1'($urandom());
      sel  = 1'($urandom());
      we   = ($urandom() % 4) != 0;
      if (($urandom() % 16) == 0) begin
        en_h = 1'($urandom());
        en_l = 1'($urandom());
      end
      if (side) host_op(sel, we, d);
      else      local_op(sel, we, d);
    end
    host_op(1'b0, 1'b0, '0);
    host_op(1'b1, 1'b0, '0);

    finish_run();
  end
endmodule